// File: doc/BRIEF.md
# Paired Counter/Timer with Split Mode

Two 8-bit-byte counter/timers, T0 and T1, share one timebase. Each timer has a two-bit mode: a 13-bit prescaled counter, a full 16-bit counter, or an 8-bit counter that reloads from its high byte when it wraps. Each timer counts either an internal timebase or the falling edges of its own synchronized count pin. T0 can also be gated by an external pin whose polarity can be selected. Software loads the counter bytes through a byte-wide write port. It clears the sticky overflow flags through clear strobes.

Mode 3 has two meanings. When T0 is in mode 3, T0 splits into two free 8-bit counters. The low byte keeps all of T0's controls and flag. The high byte counts only the internal timebase, runs while T1's run bit is set, and raises T1's flag. T1 keeps running while its own mode is 0, 1 or 2, whatever its run bit says. In that state T1 counts only the timebase, and its wraps still pulse `t1_ovf_o` for baud-rate or conversion-trigger use, but they never reach T1's flag. When T1 is in mode 3, T1 is frozen.

Top module: `pair_timer`

## Requirements
- R1: Mode 0 (`2'b00`) counts a 13-bit value made of the high byte (upper 8 bits) and bits [4:0] of the low byte. Bits [7:5] of the low byte are left unchanged. The wrap from all ones to zero is an overflow.
- R2: Mode 1 (`2'b01`) counts the high byte and the low byte as one 16-bit value. The wrap from 0xFFFF to 0 is an overflow.
- R3: Mode 2 (`2'b10`) counts the low byte only. When the low byte steps from 0xFF, it is loaded with the high byte instead of 0x00, and an overflow occurs. The high byte is not changed by counting.
- R4: An overflow sets the timer's flag on the clock edge on which the wrap happens. A flag stays set until its clear strobe is high at a clock edge. A set and a clear on the same edge leave the flag set.
- R5: The internal timebase advances on every clock edge when `tb_sel_i`=0. When `tb_sel_i`=1, it advances only on edges where `presc_en_i` is high.
- R6: With its external select bit at 1, a timer counts falling edges of its count pin instead of the timebase. The pin passes through two synchronizer flops. A fall seen before edge k is counted at edge k+2.
- R7: T0, or T0's low byte in split mode, counts only while `t0_run_i` is high. When `t0_gate_en_i`=1, it also needs `t0_gate_i` XOR `gate_pol_i` to be 1.
- R8: With `t0_mode_i`=3, T0's low byte is an independent 8-bit counter under T0's controls, and its wrap sets `tf0_o`. There is no carry into the high byte.
- R9: With `t0_mode_i`=3, T0's high byte counts the internal timebase only, regardless of `t0_ext_i`. It runs while `t1_run_i` is high, and its wrap sets `tf1_o`.
- R10: With `t0_mode_i`=3 and `t1_mode_i` in 0..2, T1 counts the internal timebase regardless of `t1_run_i` and `t1_ext_i`. Its wraps never set `tf1_o`.
- R11: With `t1_mode_i`=3, T1's counter bytes never change by counting, whatever the other inputs are.
- R12: `wr_en_i` bit 0, 1, 2 and 3 loads `wr_data_i` into T0 low, T0 high, T1 low and T1 high respectively. A write to either byte of a timer takes the place of that timer's count on that edge, so the count causes no overflow. In split mode, each half of T0 is blocked only by a write to its own byte.
- R13: `t1_ovf_o` is high for exactly the one cycle after every T1 wrap, in every T0 mode. Outside split mode, `tf1_o` is set in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| presc_en_i | input | 1 | prescaled-clock enable |
| tb_sel_i | input | 1 | timebase select: 0 system clock, 1 prescaled |
| t0_cnt_i | input | 1 | T0 external count pin |
| t1_cnt_i | input | 1 | T1 external count pin |
| t0_gate_i | input | 1 | T0 external gate pin |
| gate_pol_i | input | 1 | gate polarity (XORed with gate pin) |
| t0_mode_i | input | 2 | T0 mode |
| t1_mode_i | input | 2 | T1 mode |
| t0_run_i | input | 1 | T0 run bit |
| t1_run_i | input | 1 | T1 run bit |
| t0_ext_i | input | 1 | T0 counts pin edges when 1 |
| t1_ext_i | input | 1 | T1 counts pin edges when 1 |
| t0_gate_en_i | input | 1 | T0 gate enable |
| tf0_clr_i | input | 1 | clear strobe for T0 flag |
| tf1_clr_i | input | 1 | clear strobe for T1 flag |
| wr_en_i | input | 4 | byte write enables {T1 high, T1 low, T0 high, T0 low} |
| wr_data_i | input | 8 | write data |
| tf0_o | output | 1 | T0 overflow flag |
| tf1_o | output | 1 | T1 overflow flag |
| t1_ovf_o | output | 1 | one-cycle pulse after every T1 wrap |
| tl0_o | output | 8 | T0 low byte |
| th0_o | output | 8 | T0 high byte |
| tl1_o | output | 8 | T1 low byte |
| th1_o | output | 8 | T1 high byte |

## Verification
The hardest case to reach is split mode with T1 still running. Here T1's wrap has to pulse `t1_ovf_o` while `tf1_o` stays low, and `tf1_o` must remain free for T0's high byte alone. The stimulus parks T1 frozen in mode 3 while its bytes are loaded just below the wrap. It then moves T1 to mode 1 for a fixed window while its run bit is low and its external select is high. The bench counts the pulses sampled in that window and compares both bytes with the arithmetic count. Modes 0 to 2 are swept over start values near their wrap points and several run lengths on both timers.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } tmode_e;
endpackage

// File: rtl/pt_edge_sync.sv
module pt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/pt_flag.sv
module pt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;  // hardware set beats software clear
    else if (clr_i) flag_o <= 1'b0;
  end
endmodule

// File: rtl/pt_timer16.sv
module pt_timer16 #(
  parameter int W  = 8,
  parameter int PW = 5
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  pt_pkg::tmode_e mode_i,
  input  logic           split_i,
  input  logic           lo_en_i,
  input  logic           hi_en_i,
  input  logic           wr_lo_i,
  input  logic           wr_hi_i,
  input  logic [W-1:0]   wr_data_i,
  output logic [W-1:0]   lo_o,
  output logic [W-1:0]   hi_o,
  output logic           lo_ovf_o,
  output logic           hi_ovf_o
);
  import pt_pkg::*;

  localparam int NW = W + PW;
  localparam logic [NW:0]  ONE_N = (NW+1)'(1);
  localparam logic [2*W:0] ONE_F = (2*W+1)'(1);
  localparam logic [W:0]   ONE_B = (W+1)'(1);

  logic [W-1:0] lo_q, hi_q, lo_d, hi_d;
  logic         lo_en, hi_en;

  // a write to either byte blocks the whole counter, except halves in split mode
  assign lo_en = lo_en_i & ~wr_lo_i & (split_i | ~wr_hi_i);
  assign hi_en = hi_en_i & ~wr_hi_i & split_i;

  always_comb begin
    lo_d     = lo_q;
    hi_d     = hi_q;
    lo_ovf_o = 1'b0;
    hi_ovf_o = 1'b0;
    if (split_i) begin
      if (lo_en) {lo_ovf_o, lo_d} = {1'b0, lo_q} + ONE_B;
      if (hi_en) {hi_ovf_o, hi_d} = {1'b0, hi_q} + ONE_B;
    end else if (lo_en) begin
      unique case (mode_i)
        MODE_13:     {lo_ovf_o, hi_d, lo_d[PW-1:0]} = {1'b0, hi_q, lo_q[PW-1:0]} + ONE_N;
        MODE_16:     {lo_ovf_o, hi_d, lo_d} = {1'b0, hi_q, lo_q} + ONE_F;
        MODE_RELOAD: begin
          if (lo_q == '1) begin
            lo_d     = hi_q;
            lo_ovf_o = 1'b1;
          end else begin
            lo_d = lo_q + W'(1);
          end
        end
        default: ;
      endcase
    end
    if (wr_lo_i) lo_d = wr_data_i;
    if (wr_hi_i) hi_d = wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign lo_o = lo_q;
  assign hi_o = hi_q;
endmodule

// File: rtl/pair_timer.sv
module pair_timer #(
  parameter int W        = 8,
  parameter int PW       = 5,
  parameter int SYNC_STG = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         presc_en_i,
  input  logic         tb_sel_i,
  input  logic         t0_cnt_i,
  input  logic         t1_cnt_i,
  input  logic         t0_gate_i,
  input  logic         gate_pol_i,
  input  logic [1:0]   t0_mode_i,
  input  logic [1:0]   t1_mode_i,
  input  logic         t0_run_i,
  input  logic         t1_run_i,
  input  logic         t0_ext_i,
  input  logic         t1_ext_i,
  input  logic         t0_gate_en_i,
  input  logic         tf0_clr_i,
  input  logic         tf1_clr_i,
  input  logic [3:0]   wr_en_i,
  input  logic [W-1:0] wr_data_i,
  output logic         tf0_o,
  output logic         tf1_o,
  output logic         t1_ovf_o,
  output logic [W-1:0] tl0_o,
  output logic [W-1:0] th0_o,
  output logic [W-1:0] tl1_o,
  output logic [W-1:0] th1_o
);
  import pt_pkg::*;

  tmode_e t0_mode, t1_mode;
  logic   tick, gate_ok, t0_split, t1_halt;
  logic   t0_fall, t1_fall;
  logic   t0_lo_en, t0_hi_en, t1_en;
  logic   t0_lo_ovf, t0_hi_ovf, t1_ovf, t1_hi_unused;
  logic   tf1_set, t1_ovf_q;

  assign t0_mode  = tmode_e'(t0_mode_i);
  assign t1_mode  = tmode_e'(t1_mode_i);
  assign tick     = tb_sel_i ? presc_en_i : 1'b1;
  assign gate_ok  = ~t0_gate_en_i | (t0_gate_i ^ gate_pol_i);
  assign t0_split = (t0_mode == MODE_SPLIT);
  assign t1_halt  = (t1_mode == MODE_SPLIT);

  pt_edge_sync #(.STAGES(SYNC_STG)) i_sync0 (
    .clk_i, .rst_ni, .pin_i(t0_cnt_i), .fall_o(t0_fall)
  );
  pt_edge_sync #(.STAGES(SYNC_STG)) i_sync1 (
    .clk_i, .rst_ni, .pin_i(t1_cnt_i), .fall_o(t1_fall)
  );

  assign t0_lo_en = t0_run_i & gate_ok & (t0_ext_i ? t0_fall : tick);
  assign t0_hi_en = t1_run_i & tick;  // split high byte: internal timebase only
  // under split, T1 run follows its mode and external counting is lost
  assign t1_en    = ~t1_halt &
                    (t0_split ? tick : (t1_run_i & (t1_ext_i ? t1_fall : tick)));

  pt_timer16 #(.W(W), .PW(PW)) i_t0 (
    .clk_i, .rst_ni,
    .mode_i    (t0_mode),
    .split_i   (t0_split),
    .lo_en_i   (t0_lo_en),
    .hi_en_i   (t0_hi_en),
    .wr_lo_i   (wr_en_i[0]),
    .wr_hi_i   (wr_en_i[1]),
    .wr_data_i (wr_data_i),
    .lo_o      (tl0_o),
    .hi_o      (th0_o),
    .lo_ovf_o  (t0_lo_ovf),
    .hi_ovf_o  (t0_hi_ovf)
  );

  pt_timer16 #(.W(W), .PW(PW)) i_t1 (
    .clk_i, .rst_ni,
    .mode_i    (t1_mode),
    .split_i   (1'b0),
    .lo_en_i   (t1_en),
    .hi_en_i   (1'b0),
    .wr_lo_i   (wr_en_i[2]),
    .wr_hi_i   (wr_en_i[3]),
    .wr_data_i (wr_data_i),
    .lo_o      (tl1_o),
    .hi_o      (th1_o),
    .lo_ovf_o  (t1_ovf),
    .hi_ovf_o  (t1_hi_unused)
  );

  assign tf1_set = t0_split ? t0_hi_ovf : t1_ovf;

  pt_flag i_tf0 (.clk_i, .rst_ni, .set_i(t0_lo_ovf), .clr_i(tf0_clr_i), .flag_o(tf0_o));
  pt_flag i_tf1 (.clk_i, .rst_ni, .set_i(tf1_set),   .clr_i(tf1_clr_i), .flag_o(tf1_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) t1_ovf_q <= 1'b0;
    else         t1_ovf_q <= t1_ovf;
  end

  assign t1_ovf_o = t1_ovf_q;
endmodule

// File: rtl/pair_timer_chk.sv
module pair_timer_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   t0_mode_i,
  input logic [1:0]   t1_mode_i,
  input logic         t0_run_i,
  input logic         t1_run_i,
  input logic         tf0_clr_i,
  input logic [3:0]   wr_en_i,
  input logic         tf0_o,
  input logic         tf1_o,
  input logic         t1_ovf_o,
  input logic [W-1:0] tl0_o,
  input logic [W-1:0] th0_o,
  input logic [W-1:0] tl1_o,
  input logic [W-1:0] th1_o
);
  p_flag_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tf0_o && !tf0_clr_i) |=> tf0_o);

  p_run_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!t0_run_i && wr_en_i[1:0] == 2'b00 && t0_mode_i != 2'd3)
      |=> ($stable(tl0_o) && $stable(th0_o)));

  p_no_carry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t0_mode_i == 2'd3 && !t1_run_i && !wr_en_i[1]) |=> $stable(th0_o));

  p_split_tf1_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(tf1_o) && $past(t0_mode_i) == 2'd3) |-> $past(th0_o) == {W{1'b1}});

  p_t1_halt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_mode_i == 2'd3 && wr_en_i[3:2] == 2'b00)
      |=> ($stable(tl1_o) && $stable(th1_o)));

  p_pulse_flag_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t1_ovf_o && $past(t0_mode_i) != 2'd3) |-> tf1_o);
endmodule

bind pair_timer pair_timer_chk #(.W(W)) i_chk (.*);

// File: tb/test_pair_timer.sv
module test_pair_timer;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       presc_en_i = 0, tb_sel_i = 0, t0_cnt_i = 0, t1_cnt_i = 0;
  logic       t0_gate_i = 0, gate_pol_i = 0, t0_run_i = 0, t1_run_i = 0;
  logic       t0_ext_i = 0, t1_ext_i = 0, t0_gate_en_i = 0, tf0_clr_i = 0, tf1_clr_i = 0;
  logic [1:0] t0_mode_i = 2'd1, t1_mode_i = 2'd3;
  logic [3:0] wr_en_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       tf0_o, tf1_o, t1_ovf_o;
  logic [7:0] tl0_o, th0_o, tl1_o, th1_o;
  int checks = 0, fails = 0;

  always #4 clk_i = ~clk_i;

  pair_timer i_pair_timer (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int idx, logic [7:0] d);
    @(negedge clk_i); wr_en_i = 4'(1 << idx); wr_data_i = d;
    @(negedge clk_i); wr_en_i = '0;
  endtask

  task automatic clr_flags();
    @(negedge clk_i); tf0_clr_i = 1; tf1_clr_i = 1;
    @(negedge clk_i); tf0_clr_i = 0; tf1_clr_i = 0;
  endtask

  task automatic run(logic r0, logic r1, int k);
    @(negedge clk_i); t0_run_i = r0; t1_run_i = r1;
    repeat (k) @(negedge clk_i);
    t0_run_i = 0; t1_run_i = 0;
  endtask

  function automatic logic [16:0] model(int mode, logic [7:0] tl, logic [7:0] th, int k);
    int v; logic ovf = 0;
    case (mode)
      0: begin
        v = int'({th, tl[4:0]}) + k;
        ovf = (v >= 8192); v = v % 8192;
        tl = {tl[7:5], v[4:0]}; th = v[12:5];
      end
      1: begin
        v = int'({th, tl}) + k;
        ovf = (v >= 65536); v = v % 65536;
        th = v[15:8]; tl = v[7:0];
      end
      default: for (int i = 0; i < k; i++) begin
        if (tl == 8'hFF) begin tl = th; ovf = 1; end
        else tl = tl + 8'd1;
      end
    endcase
    return {ovf, th, tl};
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] tls[4] = '{8'h00, 8'hE0, 8'hFB, 8'hFF};
    logic [7:0] ths[2] = '{8'h00, 8'hFF};
    int ks[3] = '{1, 5, 37};
    logic [16:0] e;
    int n;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // reset state
    check("R12 reset", {tf0_o, tf1_o, t1_ovf_o, tl0_o, th0_o, tl1_o, th1_o}, 0);

    // R1 R2 R3 sweeps on both timers, R4 flag set on wrap
    for (int t = 0; t < 2; t++)
      for (int m = 0; m < 3; m++)
        for (int a = 0; a < 4; a++)
          for (int b = 0; b < 2; b++)
            for (int c = 0; c < 3; c++) begin
              if (t == 0) begin t0_mode_i = 2'(m); t1_mode_i = 2'd3; end
              else begin t0_mode_i = 2'd1; t1_mode_i = 2'(m); end
              wr(2*t, tls[a]); wr(2*t+1, ths[b]); clr_flags();
              run(t == 0, t == 1, ks[c]);
              e = model(m, tls[a], ths[b], ks[c]);
              @(negedge clk_i);
              if (t == 0) check($sformatf("R1_R2_R3 t0 mode%0d", m), {tf0_o, th0_o, tl0_o}, e);
              else        check($sformatf("R1_R2_R3 t1 mode%0d", m), {tf1_o, th1_o, tl1_o}, e);
            end
    t1_mode_i = 2'd3; t0_mode_i = 2'd1;

    // R4 set beats clear, then clear works
    wr(0, 8'hFF); wr(1, 8'hFF); clr_flags();
    @(negedge clk_i); t0_run_i = 1; tf0_clr_i = 1;
    @(negedge clk_i); t0_run_i = 0; tf0_clr_i = 0;
    check("R4 set wins over clear", tf0_o, 1);
    repeat (3) @(negedge clk_i);
    check("R4 flag sticky", tf0_o, 1);
    clr_flags();
    check("R4 clear", tf0_o, 0);

    // R5 prescaled timebase
    wr(0, 8'h00); wr(1, 8'h00); tb_sel_i = 1;
    @(negedge clk_i); t0_run_i = 1;
    for (int i = 0; i < 10; i++) begin presc_en_i = (i % 3 == 0); @(negedge clk_i); end
    t0_run_i = 0; presc_en_i = 0; tb_sel_i = 0;
    check("R5 prescaled count", tl0_o, 4);

    // R6 external count edges
    wr(0, 8'h00); t0_ext_i = 1;
    @(negedge clk_i); t0_run_i = 1;
    for (int i = 0; i < 5; i++) begin
      t0_cnt_i = 1; repeat (2) @(negedge clk_i);
      t0_cnt_i = 0; repeat (2) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    t0_run_i = 0; t0_ext_i = 0;
    check("R6 external edges", {th0_o, tl0_o}, 5);
    // R6 latency: fall before edge k counted at edge k+2
    wr(0, 8'h00); t0_ext_i = 1; t0_cnt_i = 1;
    @(negedge clk_i); t0_run_i = 1;
    repeat (3) @(negedge clk_i);
    t0_cnt_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    check("R6 not yet counted", tl0_o, 0);
    @(negedge clk_i);
    check("R6 counted at k+2", tl0_o, 1);
    t0_run_i = 0; t0_ext_i = 0;

    // R7 gate with polarity
    t0_gate_en_i = 1;
    for (int p = 0; p < 2; p++)
      for (int g = 0; g < 2; g++) begin
        gate_pol_i = p[0]; t0_gate_i = g[0];
        wr(0, 8'h00);
        run(1, 0, 6);
        check($sformatf("R7 gate pol%0d pin%0d", p, g), tl0_o, (p != g) ? 6 : 0);
      end
    t0_gate_en_i = 0; gate_pol_i = 0; t0_gate_i = 0;

    // R12 write in counting cycle blocks count
    wr(0, 8'hFF); wr(1, 8'hFF); clr_flags();
    @(negedge clk_i); t0_run_i = 1; wr_en_i = 4'b0010; wr_data_i = 8'h12;
    @(negedge clk_i); t0_run_i = 0; wr_en_i = '0;
    check("R12 write beats count", {tf0_o, th0_o, tl0_o}, 17'h012FF);

    // R8 R9 split mode
    t0_mode_i = 2'd3; t1_mode_i = 2'd3;
    wr(0, 8'hFE); wr(1, 8'hFC); clr_flags();
    run(1, 0, 3);
    check("R8 low byte wraps, no carry", {tf0_o, tf1_o, th0_o, tl0_o}, 18'h2FC01);
    t0_ext_i = 1;
    run(0, 1, 5);
    t0_ext_i = 0;
    check("R9 high byte internal, sets tf1", {tf0_o, tf1_o, th0_o, tl0_o}, 18'h30101);
    // R12 split: high-byte write leaves low byte counting
    clr_flags();
    @(negedge clk_i); t0_run_i = 1; t1_run_i = 1; wr_en_i = 4'b0010; wr_data_i = 8'h40;
    @(negedge clk_i); t0_run_i = 0; t1_run_i = 0; wr_en_i = '0;
    check("R12 split halves", {th0_o, tl0_o}, 16'h4002);

    // R10 T1 under split: runs by mode, ignores run/ext, no tf1, still pulses
    wr(2, 8'hFA); wr(3, 8'hFF); clr_flags();
    t1_ext_i = 1; n = 0;
    @(negedge clk_i); t1_mode_i = 2'd1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (t1_ovf_o) n++;
    end
    t1_mode_i = 2'd3; t1_ext_i = 0;
    @(negedge clk_i);
    if (t1_ovf_o) n++;
    check("R10 T1 count under split", {th1_o, tl1_o}, 16'h0002);
    check("R10 no tf1 from T1", tf1_o, 0);
    check("R13 one pulse under split", n, 1);

    // R11 T1 mode 3 frozen outside split
    t0_mode_i = 2'd1;
    run(0, 1, 10);
    check("R11 T1 halted", {th1_o, tl1_o}, 16'h0002);

    // R13 pulse and flag together, one cycle wide
    t1_mode_i = 2'd1; wr(2, 8'hFF); wr(3, 8'hFF); clr_flags();
    @(negedge clk_i); t1_run_i = 1;
    @(negedge clk_i); t1_run_i = 0;
    check("R13 pulse with flag", {t1_ovf_o, tf1_o}, 2'b11);
    @(negedge clk_i);
    check("R13 pulse one cycle", t1_ovf_o, 0);
    t1_mode_i = 2'd3;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule